// File: doc/BRIEF.md
# Interrupt Mask and Wakeup Controller

This block sits between the interrupt sources of a chip and its processor. It takes a bank of level-sensitive maskable requests and one non-maskable-class request, plus two mask bits from the processor's condition register. Each cycle it picks the request to present and forms its vector address from a relocatable table base. The maskable requests are gated by the I mask. The high-priority request is gated by the X mask and wins over every maskable request.

A separate wake output serves low-power states. In wait or stop mode, a maskable request raises wake only if the I mask is clear, the same rule as in run mode. The high-priority request raises wake whatever the X mask holds. No clock runs in stop mode, so wake is pure combinational logic from the requests, the masks and the mode pins.

The pending flag and the vector are registered and recomputed every cycle. A withdrawn request therefore leaves no interrupt behind. Nesting comes from the mask alone: when software clears the I mask during a service routine, other maskable requests are presented again.

Top module: `irq_mask_wake_ctrl`

## Requirements
- R1: During and after reset, `irq_pending` is 0 and `irq_vector` is 0x0000, and the table base holds its default of 0xFF80.
- R2: While `mask_i` is 1, no maskable request sets `irq_pending`. Clearing `mask_i` lets a held maskable request be presented again on the next cycle.
- R3: When `xirq_req` is 1 and `mask_x` is 0, `irq_pending` is 1 and the high-priority vector is chosen, even while maskable requests are pending and `mask_i` is 0.
- R4: While `mask_x` is 1, `xirq_req` sets neither `irq_pending` nor the vector in any mode.
- R5: Among unmasked maskable requests, bit k with the lowest index wins, and the vector is base + 2*k.
- R6: The high-priority vector is base + 2*NUM_IRQ, which is 0xFF90 at the default base with NUM_IRQ = 8.
- R7: A write through `base_wr_en`/`base_wr_data` replaces the table base. The low 7 bits of the written value are ignored, so the base stays 128-byte aligned. The vector presented in the write cycle still uses the old base, and the next cycle uses the new one.
- R8: `irq_pending` and `irq_vector` are registered. They follow the inputs of the previous clock cycle, so a request withdrawn before the next edge leaves `irq_pending` at 0 and `irq_vector` at 0.
- R9: In wait or stop mode, a maskable request drives `wake` to 1 only while `mask_i` is 0. With `mask_i` at 1, maskable requests leave `wake` at 0.
- R10: In wait or stop mode, `xirq_req` drives `wake` to 1 whatever the value of `mask_x`.
- R11: `wake` is combinational. It reacts to its inputs without a clock edge and is 0 whenever both `mode_wait` and `mode_stop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_IRQ | Level maskable requests, bit 0 highest priority |
| xirq_req | input | 1 | Level high-priority request |
| mask_i | input | 1 | I mask from the condition register, 1 blocks maskable requests |
| mask_x | input | 1 | X mask from the condition register, 1 blocks delivery of xirq_req |
| base_wr_en | input | 1 | Write strobe for the table base |
| base_wr_data | input | ADDR_W | New table base, low ALIGN_BITS ignored |
| mode_wait | input | 1 | Processor is in wait mode |
| mode_stop | input | 1 | Processor is in stop mode |
| irq_pending | output | 1 | A request is presented to the processor |
| irq_vector | output | ADDR_W | Vector address of the presented request, 0 when none |
| wake | output | 1 | Combinational wake-up request |

## Verification
The selection is exercised in three ways:
- A single maskable request shows that the vector arithmetic is right.
- Several simultaneous requests separate lowest-index priority from highest-index priority.
- Mixing `xirq_req` with maskable requests under each combination of the two masks shows the X-over-I ordering and that each mask gates only its own class.

A request raised and then dropped in the next cycle shows level behaviour against latching. A base write with a request held across it shows when relocation takes effect and that the low bits are dropped. Wake is checked in wait and stop with each mask setting, once right after the inputs change and before any edge, which shows whether it needs a clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Which source the selector chose in a cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_I    = 2'd1,
    SRC_X    = 2'd2
  } irq_src_e;

  // Byte offset of a maskable entry inside the table (16-bit entries)
  function automatic int unsigned entry_offset(input int unsigned idx);
    return idx * 2;
  endfunction

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic               mask_i,
  input  logic               xreq,
  input  logic               mask_x,
  output irq_src_e           src,
  output logic [IDX_W-1:0]   idx
);

  logic [NUM_IRQ-1:0] live;
  logic               any_live;

  assign live     = mask_i ? '0 : req;
  assign any_live = |live;

  // Lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (live[k]) idx = IDX_W'(k);
    end
  end

  always_comb begin
    if (xreq && !mask_x)  src = SRC_X;
    else if (any_live)    src = SRC_I;
    else                  src = SRC_NONE;
  end

endmodule

// File: rtl/irq_vec_base.sv
module irq_vec_base #(
  parameter int              ADDR_W     = 16,
  parameter int              ALIGN_BITS = 7,
  parameter logic [ADDR_W-1:0] RESET_BASE = 16'hFF80,
  localparam int             HI_W       = ADDR_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [HI_W-1:0]   base_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_hi <= RESET_BASE[ADDR_W-1:ALIGN_BITS];
    else if (wr_en) base_hi <= wr_data[ADDR_W-1:ALIGN_BITS];
  end

  // R7: the upper field follows the written value one edge later
  assert_base_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> base_hi == $past(wr_data[ADDR_W-1:ALIGN_BITS]));

endmodule

// File: rtl/irq_wake_logic.sv
module irq_wake_logic #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic               mask_i,
  input  logic               xreq,
  input  logic               mode_wait,
  input  logic               mode_stop,
  output logic               wake
);

  logic low_power;
  logic i_wake;

  assign low_power = mode_wait | mode_stop;
  // Maskable requests obey the run-mode mask; the X request ignores its mask
  assign i_wake    = (|req) & ~mask_i;
  assign wake      = low_power & (xreq | i_wake);

endmodule

// File: rtl/irq_mask_wake_ctrl.sv
module irq_mask_wake_ctrl
  import irq_pkg::*;
#(
  parameter int                NUM_IRQ    = 8,
  parameter int                ADDR_W     = 16,
  parameter int                ALIGN_BITS = 7,
  parameter logic [ADDR_W-1:0] RESET_BASE = 16'hFF80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               xirq_req,
  input  logic               mask_i,
  input  logic               mask_x,
  input  logic               base_wr_en,
  input  logic [ADDR_W-1:0]  base_wr_data,
  input  logic               mode_wait,
  input  logic               mode_stop,
  output logic               irq_pending,
  output logic [ADDR_W-1:0]  irq_vector,
  output logic               wake
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int HI_W  = ADDR_W - ALIGN_BITS;
  localparam logic [ALIGN_BITS-1:0] X_OFF = ALIGN_BITS'(entry_offset(NUM_IRQ));

  initial begin
    if (2 * NUM_IRQ + 2 > (1 << ALIGN_BITS))
      $error("vector table does not fit the aligned window");
  end

  irq_src_e          src;
  logic [IDX_W-1:0]  idx;
  logic [HI_W-1:0]   base_hi;
  logic [ADDR_W-1:0] vec_next;

  irq_prio_sel #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_sel (
    .req    (irq_req),
    .mask_i (mask_i),
    .xreq   (xirq_req),
    .mask_x (mask_x),
    .src    (src),
    .idx    (idx)
  );

  irq_vec_base #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .base_hi (base_hi)
  );

  irq_wake_logic #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .req       (irq_req),
    .mask_i    (mask_i),
    .xreq      (xirq_req),
    .mode_wait (mode_wait),
    .mode_stop (mode_stop),
    .wake      (wake)
  );

  always_comb begin
    unique case (src)
      SRC_X:   vec_next = {base_hi, X_OFF};
      SRC_I:   vec_next = {base_hi, ALIGN_BITS'({idx, 1'b0})};
      default: vec_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pending <= 1'b0;
      irq_vector  <= '0;
    end else begin
      irq_pending <= (src != SRC_NONE);
      irq_vector  <= vec_next;
    end
  end

  // R1: no vector without a pending request
  assert_idle_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending |-> irq_vector == '0);

  // R2: with I set and X not deliverable, nothing is presented next cycle
  assert_mask_i_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && !(xirq_req && !mask_x)) |=> !irq_pending);

  // R3 and R6: an unmasked X request is presented at its fixed slot
  assert_x_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xirq_req && !mask_x && !base_wr_en) |=>
      (irq_pending && irq_vector[ALIGN_BITS-1:0] == X_OFF));

  // R5: maskable entries are 16-bit aligned
  assert_vec_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> !irq_vector[0]);

  // R10: X request wakes in low-power modes regardless of its mask
  assert_x_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_wait || mode_stop) && xirq_req) |-> wake);

  // R11: never wake while running
  assert_run_no_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wait && !mode_stop) |-> !wake);

endmodule

// File: tb/irq_mask_wake_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_wake_ctrl_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         xirq_req = 1'b0, mask_i = 1'b1, mask_x = 1'b1;
  logic         base_wr_en = 1'b0;
  logic [15:0]  base_wr_data = '0;
  logic         mode_wait = 1'b0, mode_stop = 1'b0;
  logic         irq_pending, wake;
  logic [15:0]  irq_vector;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic        pend;
    logic [15:0] vec;
    logic        wk;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model_base = 16'hFF80;

  always #10 clk = ~clk;

  irq_mask_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .xirq_req(xirq_req),
    .mask_i(mask_i), .mask_x(mask_x), .base_wr_en(base_wr_en),
    .base_wr_data(base_wr_data), .mode_wait(mode_wait), .mode_stop(mode_stop),
    .irq_pending(irq_pending), .irq_vector(irq_vector), .wake(wake)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what must appear after the edge
  task automatic drive(input logic [N-1:0] ir, input logic xr, input logic mi, input logic mx,
                       input logic wt, input logic st, input logic we, input logic [15:0] wd,
                       input string tag);
    exp_t e;
    int   win;
    @(negedge clk);
    irq_req = ir; xirq_req = xr; mask_i = mi; mask_x = mx;
    mode_wait = wt; mode_stop = st; base_wr_en = we; base_wr_data = wd;
    e.tag  = tag;
    e.wk   = (wt | st) & (xr | ((|ir) & ~mi));
    e.pend = 1'b0;
    e.vec  = 16'h0000;
    win    = -1;
    for (int k = N - 1; k >= 0; k--) if (ir[k] && !mi) win = k;
    if (xr && !mx) begin
      e.pend = 1'b1;
      e.vec  = model_base + 16'(2 * N);
    end else if (win >= 0) begin
      e.pend = 1'b1;
      e.vec  = model_base + 16'(2 * win);
    end
    sb.push_back(e);
    if (we) model_base = wd & 16'hFF80;
    // R11: wake must settle with no clock edge in between
    #1 check({tag, " R11 wake no-edge"}, {15'd0, wake}, {15'd0, e.wk});
  endtask

  // Monitor: pops and compares shortly after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " pending"}, {15'd0, irq_pending}, {15'd0, e.pend});
      check({e.tag, " vector"}, irq_vector, e.vec);
      check({e.tag, " wake"}, {15'd0, wake}, {15'd0, e.wk});
    end
  end

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    if (!finished) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R1 reset pending", {15'd0, irq_pending}, 16'd0);
    check("R1 reset vector", irq_vector, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    drive(8'b0000_0100, 0, 0, 1, 0, 0, 0, 0, "R5 R1 single idx2");
    drive(8'b1010_0000, 0, 0, 1, 0, 0, 0, 0, "R5 lowest of 5,7");
    drive(8'b1010_0000, 0, 1, 1, 0, 0, 0, 0, "R2 I masked");
    drive(8'b1010_0000, 0, 0, 1, 0, 0, 0, 0, "R2 I cleared nest");
    drive(8'b1000_0001, 1, 0, 0, 0, 0, 0, 0, "R3 R6 X over I");
    drive(8'b0000_0000, 1, 1, 0, 0, 0, 0, 0, "R3 X with I set");
    drive(8'b1000_0000, 1, 0, 1, 0, 0, 0, 0, "R4 X masked, I wins");
    drive(8'b0000_0000, 1, 0, 1, 0, 0, 0, 0, "R4 X masked alone");
    drive(8'b0001_0000, 0, 0, 1, 0, 0, 0, 0, "R8 raise idx4");
    drive(8'b0000_0000, 0, 0, 1, 0, 0, 0, 0, "R8 withdrawn");
    drive(8'b0000_0010, 0, 0, 1, 0, 0, 1, 16'h1234, "R7 write cycle old base");
    drive(8'b0000_0010, 0, 0, 1, 0, 0, 0, 0, "R7 new base low bits dropped");
    drive(8'b0000_0001, 0, 0, 1, 1, 0, 0, 0, "R9 wait I clear wakes");
    drive(8'b0000_0001, 0, 1, 1, 0, 1, 0, 0, "R9 stop I set no wake");
    drive(8'b0000_0000, 1, 1, 1, 0, 1, 0, 0, "R10 stop X masked wakes");
    drive(8'b0000_0000, 1, 0, 0, 1, 0, 0, 0, "R10 wait X unmasked");
    drive(8'b1111_1111, 1, 0, 0, 0, 0, 0, 0, "R11 run no wake");
    drive(8'b0100_0000, 0, 0, 1, 0, 1, 1, 16'hFF80, "R7 restore base");
    drive(8'b0100_0000, 0, 0, 1, 0, 0, 0, 0, "R5 idx6 default base");
    drive(8'b0000_0000, 0, 0, 1, 0, 0, 0, 0, "R8 idle");

    repeat (3) @(posedge clk);
    #5;
    if (sb.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard actual=%0d left expected=0", sb.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule